// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block turns a raw window of six instruction bytes, read at the program counter, into the fields of one instruction. It splits the leading byte into an opcode nibble and a function nibble, finds the optional register byte and the optional four-byte constant, flags opcodes outside the defined set, and works out the address of the next sequential instruction. It is purely combinational. The fetch stage feeds it a fresh window every cycle, and the decode and PC-selection logic downstream use its outputs.

Each opcode has two properties: whether it carries a register byte, and whether it carries a constant word. The instruction length follows from these two properties alone, so it is 1, 2, 5 or 6 bytes. If the instruction memory reports an error, the decoded instruction becomes a no-op, whatever bytes arrived.

Top module: `fetch_decoder`

## Requirements
- R1: With `imem_error` low, `icode` equals bits [7:4] of byte 0 of the window and `ifun` equals bits [3:0] of byte 0. Byte 0 occupies `instr_win[7:0]`, and byte k occupies `instr_win[8k+7:8k]`.
- R2: With `imem_error` high, `icode` is 4'h1 (no-op) and `ifun` is 4'h0, whatever the window holds.
- R3: `instr_valid` is 1 exactly when `icode` is in the range 4'h0 to 4'hB. Opcodes 4'hC to 4'hF give 0.
- R4: Opcodes 2, 3, 4, 5, 6, A and B carry a register byte in byte 1. For these, `ra` is bits [7:4] of byte 1 and `rb` is bits [3:0] of byte 1.
- R5: For every other opcode, including undefined opcodes and the forced no-op, `ra` and `rb` both read 4'hF.
- R6: Opcodes 3, 4 and 5 carry a constant in bytes 2 to 5, assembled little-endian (byte 2 is the least significant byte of `valc`).
- R7: Opcodes 7 and 8 carry a constant in bytes 1 to 4, assembled little-endian (byte 1 is the least significant byte).
- R8: `valc` is zero for every opcode that carries no constant.
- R9: `valp` equals `pc` plus the instruction length, taken modulo 2^32. The length is 1 for opcodes 0, 1, 9 and C to F; 2 for opcodes 2, 6, A and B; 5 for opcodes 7 and 8; 6 for opcodes 3, 4 and 5.
- R10: With `imem_error` high, `valp` is `pc`+1, `ra` and `rb` are 4'hF, `valc` is 0 and `instr_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc | input | 32 | Address of byte 0 of the window |
| instr_win | input | 48 | Six instruction bytes, byte 0 in the low bits |
| imem_error | input | 1 | Instruction memory reported a bad address |
| icode | output | 4 | Opcode nibble |
| ifun | output | 4 | Function nibble |
| ra | output | 4 | First register field, 4'hF if absent |
| rb | output | 4 | Second register field, 4'hF if absent |
| valc | output | 32 | Constant word, zero if absent |
| valp | output | 32 | Address of the next sequential instruction |
| instr_valid | output | 1 | Opcode belongs to the defined set |

## Verification
A wrong decision on whether a register byte is present shows up at once in three places: `ra`/`rb` go to 4'hF or pick up stray bits, `valc` moves by one byte, and `valp` is off by one. The block holds no state, so every fault appears in the same cycle as the window that triggers it. Each opcode is therefore checked on all fields together, with byte patterns whose neighbouring bytes differ, so that a one-byte shift is always visible. Error windows and a program counter close to the top of the address space catch mistakes in the no-op override and in address wrap.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  typedef enum logic [3:0] {
    OP_HALT  = 4'h0,
    OP_NOP   = 4'h1,
    OP_MOVE  = 4'h2,
    OP_LDIMM = 4'h3,
    OP_STORE = 4'h4,
    OP_LOAD  = 4'h5,
    OP_ALU   = 4'h6,
    OP_JUMP  = 4'h7,
    OP_CALL  = 4'h8,
    OP_RET   = 4'h9,
    OP_PUSH  = 4'hA,
    OP_POP   = 4'hB
  } opcode_e;

  localparam logic [3:0] REG_NONE = 4'hF;
  localparam logic [3:0] FN_NONE  = 4'h0;

  function automatic logic op_has_regs(input logic [3:0] op);
    case (op)
      OP_MOVE, OP_LDIMM, OP_STORE, OP_LOAD, OP_ALU, OP_PUSH, OP_POP: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic op_has_const(input logic [3:0] op);
    case (op)
      OP_LDIMM, OP_STORE, OP_LOAD, OP_JUMP, OP_CALL: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic op_known(input logic [3:0] op);
    return op <= OP_POP;
  endfunction

  // Instruction length in bytes from the two presence flags
  function automatic int unsigned fetch_len(input logic has_regs,
                                            input logic has_const,
                                            input int unsigned word_bytes);
    return 1 + (has_regs ? 1 : 0) + (has_const ? word_bytes : 0);
  endfunction

endpackage

// File: rtl/opcode_split.sv
module opcode_split
  import fetch_pkg::*;
(
  input  logic [7:0] lead_byte,
  input  logic       mem_err,
  output logic [3:0] op,
  output logic [3:0] fn
);
  always_comb begin
    if (mem_err) begin
      op = OP_NOP;
      fn = FN_NONE;
    end else begin
      op = lead_byte[7:4];
      fn = lead_byte[3:0];
    end
  end
endmodule

// File: rtl/field_align.sv
module field_align
  import fetch_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  localparam int WIN_BYTES = WORD_BYTES + 2,
  localparam int CONST_W   = WORD_BYTES * 8
) (
  input  logic [WIN_BYTES*8-1:0] win,
  input  logic                   has_regs,
  input  logic                   has_const,
  output logic [3:0]             reg_a,
  output logic [3:0]             reg_b,
  output logic [CONST_W-1:0]     word
);
  logic [CONST_W-1:0] word_after_regs;
  logic [CONST_W-1:0] word_after_op;

  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_bytes
    assign word_after_regs[k*8 +: 8] = win[(k+2)*8 +: 8];
    assign word_after_op[k*8 +: 8]   = win[(k+1)*8 +: 8];
  end

  always_comb begin
    reg_a = has_regs ? win[15:12] : REG_NONE;
    reg_b = has_regs ? win[11:8]  : REG_NONE;
    if (!has_const)    word = '0;
    else if (has_regs) word = word_after_regs;
    else               word = word_after_op;
  end
endmodule

// File: rtl/pc_advance.sv
module pc_advance
  import fetch_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic              has_regs,
  input  logic              has_const,
  output logic [ADDR_W-1:0] next_pc
);
  logic [ADDR_W-1:0] step;
  assign step    = ADDR_W'(fetch_len(has_regs, has_const, WORD_BYTES));
  assign next_pc = pc + step;
endmodule

// File: rtl/fetch_decoder.sv
module fetch_decoder
  import fetch_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  localparam int WIN_BYTES = WORD_BYTES + 2,
  localparam int CONST_W   = WORD_BYTES * 8
) (
  input  logic [ADDR_W-1:0]      pc,
  input  logic [WIN_BYTES*8-1:0] instr_win,
  input  logic                   imem_error,
  output logic [3:0]             icode,
  output logic [3:0]             ifun,
  output logic [3:0]             ra,
  output logic [3:0]             rb,
  output logic [CONST_W-1:0]     valc,
  output logic [ADDR_W-1:0]      valp,
  output logic                   instr_valid
);
  // Named internal events, visible to the checker and in waveforms
  logic has_regs;
  logic has_const;

  opcode_split u_split (
    .lead_byte (instr_win[7:0]),
    .mem_err   (imem_error),
    .op        (icode),
    .fn        (ifun)
  );

  assign has_regs    = op_has_regs(icode);
  assign has_const   = op_has_const(icode);
  assign instr_valid = op_known(icode);

  field_align #(.WORD_BYTES(WORD_BYTES)) u_align (
    .win       (instr_win),
    .has_regs  (has_regs),
    .has_const (has_const),
    .reg_a     (ra),
    .reg_b     (rb),
    .word      (valc)
  );

  pc_advance #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_pc (
    .pc        (pc),
    .has_regs  (has_regs),
    .has_const (has_const),
    .next_pc   (valp)
  );
endmodule

// File: rtl/fetch_decoder_chk.sv
module fetch_decoder_chk #(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  localparam int WIN_BYTES = WORD_BYTES + 2,
  localparam int CONST_W   = WORD_BYTES * 8
) (
  input logic [ADDR_W-1:0]      pc,
  input logic [WIN_BYTES*8-1:0] instr_win,
  input logic                   imem_error,
  input logic [3:0]             icode,
  input logic [3:0]             ifun,
  input logic [3:0]             ra,
  input logic [3:0]             rb,
  input logic [CONST_W-1:0]     valc,
  input logic [ADDR_W-1:0]      valp,
  input logic                   instr_valid,
  input logic                   has_regs,
  input logic                   has_const
);
  localparam logic [ADDR_W-1:0] LEN_S = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] LEN_R = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] LEN_C = ADDR_W'(1 + WORD_BYTES);
  localparam logic [ADDR_W-1:0] LEN_L = ADDR_W'(2 + WORD_BYTES);

  logic [ADDR_W-1:0] delta;
  assign delta = valp - pc;

  always_comb begin
    if (!$isunknown({pc, instr_win, imem_error})) begin
      // R1
      split_lead_chk: assert (imem_error || {icode, ifun} == instr_win[7:0]);
      // R2
      err_nop_chk: assert (!imem_error || (icode == 4'h1 && ifun == 4'h0));
      // R3
      valid_range_chk: assert (instr_valid == (icode < 4'hC));
      // R5
      no_regbyte_chk: assert (has_regs || (ra == 4'hF && rb == 4'hF));
      // R4
      regbyte_chk: assert (!has_regs || {ra, rb} == instr_win[15:8]);
      // R8
      no_const_chk: assert (has_const || valc == '0);
      // R9
      len_set_chk: assert (delta == LEN_S || delta == LEN_R ||
                           delta == LEN_C || delta == LEN_L);
      // R10
      err_step_chk: assert (!imem_error || (delta == LEN_S && instr_valid));
    end
  end
endmodule

bind fetch_decoder fetch_decoder_chk #(
  .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)
) u_chk (
  .pc(pc), .instr_win(instr_win), .imem_error(imem_error),
  .icode(icode), .ifun(ifun), .ra(ra), .rb(rb), .valc(valc),
  .valp(valp), .instr_valid(instr_valid),
  .has_regs(has_regs), .has_const(has_const)
);

// File: tb/fetch_decoder_bench.sv
module fetch_decoder_bench;
  logic        clk = 1'b0;
  logic [31:0] pc = '0;
  logic [47:0] instr_win = '0;
  logic        imem_error = 1'b0;
  logic [3:0]  icode, ifun, ra, rb;
  logic [31:0] valc, valp;
  logic        instr_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  fetch_decoder u_fetch_decoder (
    .pc(pc), .instr_win(instr_win), .imem_error(imem_error),
    .icode(icode), .ifun(ifun), .ra(ra), .rb(rb), .valc(valc),
    .valp(valp), .instr_valid(instr_valid)
  );

  typedef struct {
    logic [3:0]  e_icode, e_ifun, e_ra, e_rb;
    logic [31:0] e_valc, e_valp;
    logic        e_valid;
    bit          err, regs, cnst;
  } item_t;

  item_t sb_q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Expected item from a length table, independent of the design
  function automatic item_t model(input logic [31:0] p, input logic [47:0] w,
                                  input bit err);
    item_t it;
    logic [3:0] op;
    int len;
    op = err ? 4'h1 : w[7:4];
    it.err = err;
    it.e_icode = op;
    it.e_ifun  = err ? 4'h0 : w[3:0];
    case (op)
      4'h2, 4'h6, 4'hA, 4'hB: len = 2;
      4'h7, 4'h8:             len = 5;
      4'h3, 4'h4, 4'h5:       len = 6;
      default:                len = 1;
    endcase
    it.regs = (len == 2 || len == 6);
    it.cnst = (len >= 5);
    it.e_ra = it.regs ? w[15:12] : 4'hF;
    it.e_rb = it.regs ? w[11:8]  : 4'hF;
    if (len == 6)      it.e_valc = {w[47:40], w[39:32], w[31:24], w[23:16]};
    else if (len == 5) it.e_valc = {w[39:32], w[31:24], w[23:16], w[15:8]};
    else               it.e_valc = 32'h0;
    it.e_valp  = p + 32'(len);
    it.e_valid = (op <= 4'hB);
    return it;
  endfunction

  task automatic drive(input logic [31:0] p, input logic [47:0] w, input bit err);
    @(posedge clk);
    pc = p;
    instr_win = w;
    imem_error = err;
    sb_q.push_back(model(p, w, err));
  endtask

  // Monitor: compares at the falling edge, away from the driving edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      chk(icode == it.e_icode, it.err ? "R2" : "R1", "icode", 32'(icode), 32'(it.e_icode));
      chk(ifun == it.e_ifun, it.err ? "R2" : "R1", "ifun", 32'(ifun), 32'(it.e_ifun));
      chk(instr_valid == it.e_valid, it.err ? "R10" : "R3", "instr_valid",
          32'(instr_valid), 32'(it.e_valid));
      chk({ra, rb} == {it.e_ra, it.e_rb}, it.err ? "R10" : (it.regs ? "R4" : "R5"),
          "ra_rb", 32'({ra, rb}), 32'({it.e_ra, it.e_rb}));
      chk(valc == it.e_valc,
          it.err ? "R10" : (!it.cnst ? "R8" : (it.regs ? "R6" : "R7")),
          "valc", valc, it.e_valc);
      chk(valp == it.e_valp, it.err ? "R10" : "R9", "valp", valp, it.e_valp);
    end
  end

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // Idle window at start: all-zero bytes decode as a 1-byte halt (R1, R9)
    drive(32'h0, 48'h0, 1'b0);
    // Every opcode with three byte patterns whose neighbouring bytes differ
    for (int op = 0; op < 16; op++) begin
      for (int pat = 0; pat < 3; pat++) begin
        logic [47:0] w;
        for (int k = 1; k < 6; k++)
          w[k*8 +: 8] = 8'(8'h13 * k + 8'h5A * pat + 8'h21 * op);
        w[7:0] = {4'(op), 4'(pat * 5 + 1)};
        drive(32'h0000_1000 + 32'(op * 64 + pat * 8), w, 1'b0);
      end
    end
    // R2, R10: memory error overrides constant-bearing and undefined bytes
    drive(32'h0000_2000, 48'hDDCC_BBAA_1234, 1'b1);
    drive(32'h0000_2100, 48'h4433_2211_0F30, 1'b1);
    drive(32'hFFFF_FFFF, 48'h0000_0000_00F0, 1'b1);
    // R9: wrap of the next address past the top of the space
    drive(32'hFFFF_FFFE, 48'h8877_6655_4430, 1'b0);
    drive(32'hFFFF_FFFC, 48'h0403_0201_0070, 1'b0);
    drive(32'hFFFF_FFFF, 48'h0000_0000_1260, 1'b0);
    // R6, R7: all-ones constants
    drive(32'h0000_0040, 48'hFFFF_FFFF_F350, 1'b0);
    drive(32'h0000_0080, 48'h00FF_FFFF_FF80, 1'b0);
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule